// File: doc/BRIEF.md
# Octet Bit-Column Serial/Parallel MAC Element

This processing element belongs to a weight-stationary systolic column. It holds eight signed 8-bit weights, one per lane. In each cycle it takes one bit from each of eight separate activations, all from the same bit position. Each activation bit gates its own lane's weight. The eight gated weights are summed by a combinational adder tree. The tree result is then added to, or subtracted from, the partial sum arriving from the element above. The registered result goes to the element below.

Activations are streamed most significant bit first. A flag marks the cycle that carries the two's complement sign bit. On that cycle the tree result is subtracted rather than added, because the sign bit has negative weight. Shift-accumulation across bit positions happens outside this element. Weights are loaded through a byte-wide shift chain, one weight per load cycle.

Top module: `osp_bitcol_mac`

## Requirements
- R1: A cycle with `rst` high clears `psum_out` to 0 on that edge and clears all eight lane weights to 0. After reset, any activation column therefore passes `psum_in` through unchanged.
- R2: On each edge where `wgt_load` is high, `wgt_in` enters lane 0, each lane k (k = 1..7) takes the previous content of lane k-1, and the old lane-7 weight is discarded. After eight consecutive loads, the first word loaded sits in lane 7.
- R3: While `wgt_load` is low, the lane weights keep their values whatever `wgt_in` carries.
- R4: Bit i of `act_col` gates lane i's weight: a lane contributes its weight when its bit is 1 and zero when its bit is 0.
- R5: On an edge where `act_msb` is low, `psum_out` becomes `psum_in` plus S, where S is the signed sum of the gated lane weights.
- R6: On an edge where `act_msb` is high, `psum_out` becomes `psum_in` minus S.
- R7: Weights, `psum_in` and `psum_out` are two's complement. The result is taken modulo 2^PSUM_W (15 bits by default).
- R8: When `wgt_load` is high in the same cycle as an accumulation, the accumulation uses the weights held before that edge.
- R9: The tree is wide enough for the extremes. With all weights at -128 and all bits set, S is -1024; in a sign-bit cycle, -S is +1024.
- R10: `psum_out` reflects the inputs sampled at the preceding rising edge, a latency of exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wgt_load | input | 1 | Shift `wgt_in` into the weight chain this cycle |
| wgt_in | input | 8 | Signed weight word entering lane 0 |
| act_col | input | 8 | One bit per activation lane, all at the same bit position |
| act_msb | input | 1 | High when `act_col` carries the sign bits |
| psum_in | input | 15 | Signed partial sum from the element above |
| psum_out | output | 15 | Registered signed partial sum to the element below |

## Verification
Weight loading and accumulation can fall in the same cycle. When they do, the accumulation must use the weights held before the edge while the chain shifts. The bench provokes this by holding `wgt_load` high during cycles with active, random activation columns and random sign flags. A reference model updates its weight queue only after it has computed the expected partial sum for that cycle. Every `psum_out` value that follows is compared against the model, so a design that used the freshly shifted weights would miscompare at once.

// File: rtl/osp_pkg.sv
package osp_pkg;
  localparam int unsigned OSP_LANES  = 8;
  localparam int unsigned OSP_WGT_W  = 8;
  localparam int unsigned OSP_PSUM_W = 15;

  // Width needed to sum 'lanes' signed values of width 'w' without overflow.
  function automatic int unsigned tree_width(input int unsigned lanes, input int unsigned w);
    return w + $clog2(lanes);
  endfunction
endpackage

// File: rtl/osp_wgt_chain.sv
module osp_wgt_chain #(
  parameter int unsigned LANES = 8,
  parameter int unsigned WGT_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load,
  input  logic [WGT_W-1:0]       din,
  output logic [LANES*WGT_W-1:0] wflat
);
  logic [WGT_W-1:0] w_q [LANES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < LANES; k++) w_q[k] <= '0;
    end else if (load) begin
      w_q[0] <= din;
      for (int k = 1; k < LANES; k++) w_q[k] <= w_q[k-1];
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_flat
    assign wflat[g*WGT_W +: WGT_W] = w_q[g];
  end

  // R2: new word lands in lane 0
  a_r2_enter: assert property (@(posedge clk) disable iff (rst)
    load |=> (w_q[0] == $past(din)));

  for (genvar g = 1; g < LANES; g++) begin : g_shift_chk
    // R2: each lane takes its lower neighbour
    a_r2_shift: assert property (@(posedge clk) disable iff (rst)
      load |=> (w_q[g] == $past(w_q[g-1])));
  end

  // R3: chain frozen while not loading
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(wflat));
endmodule

// File: rtl/osp_bitcol_tree.sv
module osp_bitcol_tree #(
  parameter int unsigned LANES = 8,
  parameter int unsigned WGT_W = 8,
  parameter int unsigned SUM_W = 11
) (
  input  logic [LANES-1:0]          act,
  input  logic [LANES*WGT_W-1:0]    wflat,
  output logic signed [SUM_W-1:0]   sum
);
  // Heap-indexed binary tree: leaves at LANES-1 .. 2*LANES-2, root at 0.
  // LANES must be a power of two.
  localparam int unsigned NODES = 2*LANES - 1;

  logic signed [SUM_W-1:0] node [NODES];
  logic signed [SUM_W-1:0] leaf_ext [LANES];

  for (genvar l = 0; l < LANES; l++) begin : g_leaf
    assign leaf_ext[l] = {{(SUM_W-WGT_W){wflat[l*WGT_W+WGT_W-1]}}, wflat[l*WGT_W +: WGT_W]};
    assign node[LANES-1+l] = act[l] ? leaf_ext[l] : '0;
  end

  for (genvar n = 0; n < LANES-1; n++) begin : g_add
    assign node[n] = node[2*n+1] + node[2*n+2];
  end

  assign sum = node[0];

  // R4: an all-zero column contributes nothing
  always_comb begin
    if (act == '0) a_r4_idle: assert (sum == '0);
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
    // R4: a single set bit selects exactly its own lane's weight
    always_comb begin
      if (act == (LANES'(1) << l)) a_r4_lane_select: assert (sum == leaf_ext[l]);
    end
  end
endmodule

// File: rtl/osp_psum_stage.sv
module osp_psum_stage #(
  parameter int unsigned SUM_W  = 11,
  parameter int unsigned PSUM_W = 15
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     msb,
  input  logic signed [SUM_W-1:0]  tree_sum,
  input  logic signed [PSUM_W-1:0] psum_in,
  output logic signed [PSUM_W-1:0] psum_out
);
  logic signed [PSUM_W-1:0] ext;
  logic signed [PSUM_W-1:0] nxt;
  logic signed [PSUM_W-1:0] psum_q;
  logic                     rst_d;

  // Extend before negating: -(-1024) needs one more bit than the tree has.
  assign ext = {{(PSUM_W-SUM_W){tree_sum[SUM_W-1]}}, tree_sum};
  assign nxt = msb ? (psum_in - ext) : (psum_in + ext);

  always_ff @(posedge clk) begin
    if (rst) psum_q <= '0;
    else     psum_q <= nxt;
  end

  always_ff @(posedge clk) rst_d <= rst;

  assign psum_out = psum_q;

  // R1: output cleared in the cycle after a reset edge
  always @(posedge clk) begin
    if (rst_d == 1'b1) a_r1_zero: assert (psum_q == '0);
  end

  // R5/R10: a zero tree result passes the incoming sum through one cycle later
  a_r5_passthru: assert property (@(posedge clk) disable iff (rst)
    (tree_sum == '0) |=> (psum_q == $past(psum_in)));
endmodule

// File: rtl/osp_bitcol_mac.sv
module osp_bitcol_mac
  import osp_pkg::*;
#(
  parameter int unsigned LANES  = OSP_LANES,
  parameter int unsigned WGT_W  = OSP_WGT_W,
  parameter int unsigned PSUM_W = OSP_PSUM_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wgt_load,
  input  logic [WGT_W-1:0]         wgt_in,
  input  logic [LANES-1:0]         act_col,
  input  logic                     act_msb,
  input  logic signed [PSUM_W-1:0] psum_in,
  output logic signed [PSUM_W-1:0] psum_out
);
  localparam int unsigned SUM_W = tree_width(LANES, WGT_W);

  logic [LANES*WGT_W-1:0] wflat;
  logic signed [SUM_W-1:0] tree_sum;

  osp_wgt_chain #(.LANES(LANES), .WGT_W(WGT_W)) u_chain (
    .clk   (clk),
    .rst   (rst),
    .load  (wgt_load),
    .din   (wgt_in),
    .wflat (wflat)
  );

  osp_bitcol_tree #(.LANES(LANES), .WGT_W(WGT_W), .SUM_W(SUM_W)) u_tree (
    .act   (act_col),
    .wflat (wflat),
    .sum   (tree_sum)
  );

  osp_psum_stage #(.SUM_W(SUM_W), .PSUM_W(PSUM_W)) u_acc (
    .clk      (clk),
    .rst      (rst),
    .msb      (act_msb),
    .tree_sum (tree_sum),
    .psum_in  (psum_in),
    .psum_out (psum_out)
  );
endmodule

// File: tb/test_osp_bitcol_mac.sv
module test_osp_bitcol_mac;
  localparam int LANES  = 8;
  localparam int WGT_W  = 8;
  localparam int PSUM_W = 15;

  logic clk = 1'b0;
  logic rst, wgt_load, act_msb;
  logic [WGT_W-1:0] wgt_in;
  logic [LANES-1:0] act_col;
  logic signed [PSUM_W-1:0] psum_in, psum_out;

  osp_bitcol_mac i_osp_bitcol_mac (
    .clk(clk), .rst(rst), .wgt_load(wgt_load), .wgt_in(wgt_in),
    .act_col(act_col), .act_msb(act_msb), .psum_in(psum_in), .psum_out(psum_out)
  );

  always #10 clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;
  int mw [LANES];
  logic [PSUM_W-1:0] exp_q;
  string exp_req;
  bit primed = 0;
  bit done = 0;

  // Compare the previous cycle's prediction, then drive and predict anew.
  task automatic step(input bit r, input bit ld, input int win, input logic [LANES-1:0] a,
                      input bit m, input int pin, input string req);
    int s;
    int v;
    @(negedge clk);
    if (primed) begin
      n_vec++;
      if (psum_out !== exp_q) begin
        n_bad++;
        $display("FAIL %s: psum_out=%0d expected %0d", exp_req, psum_out, $signed(exp_q));
      end
    end
    rst = r; wgt_load = ld; wgt_in = WGT_W'(win); act_col = a; act_msb = m;
    psum_in = PSUM_W'(pin);
    if (r) begin
      exp_q = '0;
      for (int k = 0; k < LANES; k++) mw[k] = 0;
    end else begin
      s = 0;
      for (int k = 0; k < LANES; k++) if (a[k]) s += mw[k];
      v = $signed(psum_in) + (m ? -s : s);
      exp_q = PSUM_W'(v);
      if (ld) begin
        for (int k = LANES-1; k > 0; k--) mw[k] = mw[k-1];
        mw[0] = int'($signed(WGT_W'(win)));
      end
    end
    exp_req = req;
    primed = 1;
  endtask

  initial begin
    int tgt [LANES];
    tgt = '{-128, 127, -1, 1, 5, -7, 64, -33};
    // R1: reset state and zero weights afterwards
    repeat (3) step(1, 0, 0, '0, 0, 0, "R1");
    step(0, 0, 0, 8'hFF, 0, 123, "R1");
    step(0, 0, 0, 8'hFF, 1, -77, "R1");
    // R2: load eight distinct weights, last pushed lands in lane 0
    for (int k = LANES-1; k >= 0; k--) step(0, 1, tgt[k], '0, 0, k*100 - 300, "R2");
    // R4: one lane at a time, both polarities
    for (int k = 0; k < LANES; k++) step(0, 0, 0, 8'(1 << k), 0, 0, "R4");
    for (int k = 0; k < LANES; k++) step(0, 0, 0, 8'(1 << k), 1, 50, "R4");
    // R5/R6/R10: random columns and sign flags
    for (int i = 0; i < 60; i++) begin
      bit m = 1'($urandom);
      step(0, 0, 0, 8'($urandom), m, int'($urandom_range(0, 4000)) - 2000, m ? "R6" : "R5");
    end
    // R3: wgt_in toggles with load low
    for (int i = 0; i < 30; i++)
      step(0, 0, int'($urandom), 8'($urandom), 1'($urandom), 0, "R3");
    // R8: load while accumulating
    for (int i = 0; i < 40; i++)
      step(0, 1, int'($urandom), 8'($urandom), 1'($urandom),
           int'($urandom_range(0, 2000)) - 1000, "R8");
    // R9: extremes
    for (int k = 0; k < LANES; k++) step(0, 1, -128, '0, 0, 0, "R9");
    step(0, 0, 0, 8'hFF, 0, 0, "R9");
    step(0, 0, 0, 8'hFF, 1, 0, "R9");
    // R7: wrap at both ends of the partial-sum range
    step(0, 0, 0, 8'hFF, 0, -16384, "R7");
    step(0, 0, 0, 8'hFF, 1, 16383, "R7");
    for (int i = 0; i < 30; i++)
      step(0, 0, 0, 8'($urandom), 1'($urandom), int'($urandom_range(0, 32767)) - 16384, "R7");
    // R1: reset mid-run clears output and weights
    step(1, 0, 0, 8'hFF, 0, 999, "R1");
    step(0, 0, 0, 8'hFF, 0, 321, "R1");
    step(0, 0, 0, '0, 0, 0, "R1");
    step(0, 0, 0, '0, 0, 0, "R1");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule